// File: doc/BRIEF.md
# Word-Serial Configuration Loader

This block fills the coefficient banks and the 32-bit configuration registers of a video filter from a narrow 12-bit word bus. A transaction opens while the active-low load enable `ld_n` is held low. The first word accepted in a transaction is an address. Its top three bits pick the kind of target, and its low bits pick an index within that kind. A fixed number of data words follows. A register target takes four words, each carrying one byte. A coefficient target takes eight words, and each word goes to one bank at the addressed tap index.

The bus is a push-only stream with no ready signal, because the block accepts a word on every clock. The sender holds `pause` high to mark a cycle with no valid word; this works as an inverted valid. The block never applies back-pressure. A paused cycle costs one cycle and does not lose the sequence position.

The stored values are exposed for the datapath. These are the round and control registers, the limit-select field of the control register, the two halves of the limit register that the select field picks, and a combinational read port into the coefficient banks.

Top module: `cfgl_loader`

## Requirements
- R1: After reset, every stored register and coefficient is zero, so `round_q`, `ctrl_q`, `lim_sel`, `lim_upper`, `lim_lower` and `rd_coef` read zero.
- R2: A word on `cf_word` is accepted only on a rising edge where `ld_n` is 0 and `pause` is 0. While `ld_n` is 1, nothing is stored. The first accepted word of a transaction is the address.
- R3: Address bits [11:9] select the target: 0 selects a coefficient set at tap index bits [3:0], 1 the round register, 2 limit register number bits [3:0], and 3 the control register. Values 4 to 7 store nothing for the rest of the transaction.
- R4: A 32-bit register is assembled from `cf_word[7:0]` of its four data words, least significant byte first. Bits [11:8] of those words are ignored.
- R5: A 32-bit register changes only on the edge that accepts its fourth data word. Earlier words leave its visible value unchanged.
- R6: A cycle with `pause` at 1 (and `ld_n` at 0) is ignored. The word on the bus is not stored, and the position in the sequence holds.
- R7: A coefficient transaction writes its eight data words, in order, to banks 0 through 7 at the addressed tap index. Each word is committed on the edge that accepts it.
- R8: Raising `ld_n` before a sequence completes discards any partly assembled register value. The next transaction starts again with an address word.
- R9: After a transaction's last data word, further words are ignored until `ld_n` goes high.
- R10: `lim_sel` is control-register bits [3:0]. `lim_upper` is bits [31:16] and `lim_lower` is bits [15:0] of the limit register it selects.
- R11: `rd_coef` shows, in the same cycle, the coefficient stored in bank `rd_bank` at tap `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_n | input | 1 | Load enable, active low; high ends a transaction |
| pause | input | 1 | Sender hold; high marks the current word as not valid |
| cf_word | input | 12 | Address or data word |
| rd_bank | input | 3 | Coefficient read bank select |
| rd_idx | input | 4 | Coefficient read tap index |
| rd_coef | output | 12 | Coefficient at rd_bank / rd_idx |
| round_q | output | 32 | Round register |
| ctrl_q | output | 32 | Control register |
| lim_sel | output | 4 | Limit select field from the control register |
| lim_upper | output | 16 | Upper limit of the selected limit register |
| lim_lower | output | 16 | Lower limit of the selected limit register |

## Verification
The assertions assume that `ld_n`, `pause` and `cf_word` change only away from the rising edge and hold one value per cycle. They also assume that the read selects stay inside the bank and tap ranges. The stimulus drives every input just after a rising edge, so each accepted word is stable for a full cycle. Paused cycles carry deliberately different words, which shows that the held position is really held. Aborted and over-long transactions are placed between complete ones, so each discard shows at the register outputs before the next write can hide it.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    TGT_COEF  = 3'd0,
    TGT_ROUND = 3'd1,
    TGT_LIMIT = 3'd2,
    TGT_CTRL  = 3'd3,
    TGT_RSV4  = 3'd4,
    TGT_RSV5  = 3'd5,
    TGT_RSV6  = 3'd6,
    TGT_RSV7  = 3'd7
  } tgt_e;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  function automatic logic tgt_known(input tgt_e t);
    return (t == TGT_COEF) || (t == TGT_ROUND) ||
           (t == TGT_LIMIT) || (t == TGT_CTRL);
  endfunction

endpackage

// File: rtl/cfgl_word_seq.sv
module cfgl_word_seq
  import cfgl_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int BANKS     = 8,
  parameter int REG_WORDS = 4,
  parameter int BYTE_W    = 8,
  parameter int IDX_W     = 4,
  parameter int SEL_W     = 4,
  parameter int CNT_W     = $clog2(BANKS),
  parameter int REG_W     = REG_WORDS * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic              pause,
  input  logic [WORD_W-1:0] word,
  output logic              coef_we,
  output logic [CNT_W-1:0]  coef_bank,
  output logic [IDX_W-1:0]  coef_idx,
  output logic [WORD_W-1:0] coef_data,
  output logic              reg_we,
  output tgt_e              reg_tgt,
  output logic [SEL_W-1:0]  reg_sel,
  output logic [REG_W-1:0]  reg_val
);

  localparam int LO_W = WORD_W - CLS_W;
  localparam logic [CNT_W-1:0] LAST_COEF = CNT_W'(BANKS - 1);
  localparam logic [CNT_W-1:0] LAST_REG  = CNT_W'(REG_WORDS - 1);

  phase_e            phase_q;
  tgt_e              tgt_q;
  logic [LO_W-1:0]   addr_lo_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [REG_W-1:0]  acc_q;
  logic              take;
  logic              data_take;
  logic              last_word;
  logic              is_coef;
  logic [REG_W-1:0]  merged;

  assign take      = !ld_n && !pause;
  assign data_take = take && (phase_q == PH_DATA);
  assign is_coef   = (tgt_q == TGT_COEF);
  assign last_word = is_coef ? (cnt_q == LAST_COEF) : (cnt_q == LAST_REG);

  // current byte merged over the bytes gathered so far
  always_comb begin
    merged = acc_q;
    for (int k = 0; k < REG_WORDS; k++) begin
      if (int'(cnt_q) == k) merged[k*BYTE_W +: BYTE_W] = word[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_ADDR;
      tgt_q     <= TGT_COEF;
      addr_lo_q <= '0;
      cnt_q     <= '0;
      acc_q     <= '0;
    end else if (ld_n) begin
      phase_q <= PH_ADDR;
      cnt_q   <= '0;
    end else if (take) begin
      unique case (phase_q)
        PH_ADDR: begin
          tgt_q     <= tgt_e'(word[WORD_W-1 -: CLS_W]);
          addr_lo_q <= word[LO_W-1:0];
          cnt_q     <= '0;
          acc_q     <= '0;
          phase_q   <= tgt_known(tgt_e'(word[WORD_W-1 -: CLS_W])) ? PH_DATA : PH_DONE;
        end
        PH_DATA: begin
          if (!is_coef) acc_q <= merged;
          if (last_word) phase_q <= PH_DONE;
          else           cnt_q   <= cnt_q + 1'b1;
        end
        default: phase_q <= PH_DONE;
      endcase
    end
  end

  assign coef_we   = data_take && is_coef;
  assign coef_bank = cnt_q;
  assign coef_idx  = addr_lo_q[IDX_W-1:0];
  assign coef_data = word;
  assign reg_we    = data_take && !is_coef && last_word;
  assign reg_tgt   = tgt_q;
  assign reg_sel   = addr_lo_q[SEL_W-1:0];
  assign reg_val   = merged;

  a_r6_pause_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !ld_n) |=> (cnt_q == $past(cnt_q)) && (phase_q == $past(phase_q)))
    else $error("R6 sequence position moved during pause");

  a_r8_high_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> (phase_q == PH_ADDR) && (cnt_q == '0))
    else $error("R8 sequence not back at address after ld_n high");

  a_r9_done_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE && !ld_n) |=> (phase_q == PH_DONE))
    else $error("R9 finished transaction left done phase");

endmodule

// File: rtl/cfgl_regfile.sv
module cfgl_regfile
  import cfgl_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int SEL_W  = 4,
  parameter int HALF_W = REG_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  tgt_e              reg_tgt,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [REG_W-1:0]  reg_val,
  output logic [REG_W-1:0]  round_q,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [SEL_W-1:0]  lim_sel,
  output logic [HALF_W-1:0] lim_upper,
  output logic [HALF_W-1:0] lim_lower
);

  localparam int NUM_LIM = 1 << SEL_W;

  logic [REG_W-1:0] lim_q [NUM_LIM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      round_q <= '0;
      ctrl_q  <= '0;
    end else if (reg_we) begin
      if (reg_tgt == TGT_ROUND) round_q <= reg_val;
      if (reg_tgt == TGT_CTRL)  ctrl_q  <= reg_val;
    end
  end

  for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
    always_ff @(posedge clk) begin
      if (!rst_n) lim_q[g] <= '0;
      else if (reg_we && reg_tgt == TGT_LIMIT && reg_sel == SEL_W'(g))
        lim_q[g] <= reg_val;
    end
  end

  assign lim_sel   = ctrl_q[SEL_W-1:0];
  assign lim_upper = lim_q[lim_sel][REG_W-1 -: HALF_W];
  assign lim_lower = lim_q[lim_sel][HALF_W-1:0];

  a_r5_ctrl_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_tgt == TGT_CTRL) |=> $stable(ctrl_q))
    else $error("R5 control register changed without a completing word");

endmodule

// File: rtl/cfgl_coef_banks.sv
module cfgl_coef_banks #(
  parameter int BANKS  = 8,
  parameter int DEPTH  = 16,
  parameter int COEF_W = 12,
  parameter int BANK_W = $clog2(BANKS),
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [COEF_W-1:0] wr_data,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [COEF_W-1:0] rd_data
);

  logic [COEF_W-1:0] bank_rd [BANKS];
  logic [BANKS-1:0]  bank_we;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [COEF_W-1:0] mem [DEPTH];

    assign bank_we[b] = wr_en && (wr_bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (bank_we[b]) begin
        mem[wr_idx] <= wr_data;
      end
    end

    assign bank_rd[b] = mem[rd_idx];

    a_r7_coef_commit: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we[b] |=> (mem[$past(wr_idx)] == $past(wr_data)))
      else $error("R7 coefficient not committed on its own edge");
  end

  assign rd_data = bank_rd[rd_bank];

endmodule

// File: rtl/cfgl_loader.sv
module cfgl_loader
  import cfgl_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int BANKS     = 8,
  parameter int DEPTH     = 16,
  parameter int REG_WORDS = 4,
  parameter int BYTE_W    = 8,
  parameter int SEL_W     = 4,
  parameter int BANK_W    = $clog2(BANKS),
  parameter int IDX_W     = $clog2(DEPTH),
  parameter int REG_W     = REG_WORDS * BYTE_W,
  parameter int HALF_W    = REG_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic              pause,
  input  logic [WORD_W-1:0] cf_word,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_coef,
  output logic [REG_W-1:0]  round_q,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [SEL_W-1:0]  lim_sel,
  output logic [HALF_W-1:0] lim_upper,
  output logic [HALF_W-1:0] lim_lower
);

  logic              coef_we;
  logic [BANK_W-1:0] coef_bank;
  logic [IDX_W-1:0]  coef_idx;
  logic [WORD_W-1:0] coef_data;
  logic              reg_we;
  tgt_e              reg_tgt;
  logic [SEL_W-1:0]  reg_sel;
  logic [REG_W-1:0]  reg_val;

  cfgl_word_seq #(
    .WORD_W(WORD_W), .BANKS(BANKS), .REG_WORDS(REG_WORDS), .BYTE_W(BYTE_W),
    .IDX_W(IDX_W), .SEL_W(SEL_W), .CNT_W(BANK_W), .REG_W(REG_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .pause(pause), .word(cf_word),
    .coef_we(coef_we), .coef_bank(coef_bank), .coef_idx(coef_idx),
    .coef_data(coef_data), .reg_we(reg_we), .reg_tgt(reg_tgt),
    .reg_sel(reg_sel), .reg_val(reg_val)
  );

  cfgl_regfile #(
    .REG_W(REG_W), .SEL_W(SEL_W), .HALF_W(HALF_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_tgt(reg_tgt),
    .reg_sel(reg_sel), .reg_val(reg_val), .round_q(round_q), .ctrl_q(ctrl_q),
    .lim_sel(lim_sel), .lim_upper(lim_upper), .lim_lower(lim_lower)
  );

  cfgl_coef_banks #(
    .BANKS(BANKS), .DEPTH(DEPTH), .COEF_W(WORD_W), .BANK_W(BANK_W), .IDX_W(IDX_W)
  ) u_coef (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_bank(coef_bank),
    .wr_idx(coef_idx), .wr_data(coef_data), .rd_bank(rd_bank),
    .rd_idx(rd_idx), .rd_data(rd_coef)
  );

  a_r2_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> $stable(round_q) && $stable(ctrl_q))
    else $error("R2 register changed while load enable inactive");

  a_r5_round_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(round_q) |-> $past(!ld_n && !pause))
    else $error("R5 round register changed without an accepted word");

  a_r10_sel_tracks_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    lim_sel == ctrl_q[SEL_W-1:0])
    else $error("R10 limit select differs from control field");

endmodule

// File: tb/cfgl_loader_tb.sv
module cfgl_loader_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_n = 1'b1;
  logic        pause = 1'b0;
  logic [11:0] cf_word = '0;
  logic [2:0]  rd_bank = '0;
  logic [3:0]  rd_idx = '0;
  logic [11:0] rd_coef;
  logic [31:0] round_q, ctrl_q;
  logic [3:0]  lim_sel;
  logic [15:0] lim_upper, lim_lower;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #(CLK_P/2) clk = ~clk;

  cfgl_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .pause(pause), .cf_word(cf_word),
    .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_coef(rd_coef), .round_q(round_q),
    .ctrl_q(ctrl_q), .lim_sel(lim_sel), .lim_upper(lim_upper), .lim_lower(lim_lower)
  );

  // behavioural reference
  int          m_ph, m_cls, m_sel, m_cnt;
  logic [31:0] m_acc, m_round, m_ctrl;
  logic [31:0] m_lim [16];
  logic [11:0] m_coef [8][16];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_acc = 0; m_round = 0; m_ctrl = 0;
      foreach (m_lim[i]) m_lim[i] = 0;
      foreach (m_coef[i, j]) m_coef[i][j] = 0;
    end else if (ld_n) begin
      m_ph = 0;
    end else if (!pause) begin
      if (m_ph == 0) begin
        m_cls = int'(cf_word[11:9]); m_sel = int'(cf_word[3:0]);
        m_cnt = 0; m_acc = 0;
        m_ph = (m_cls < 4) ? 1 : 2;
      end else if (m_ph == 1) begin
        if (m_cls == 0) begin
          m_coef[m_cnt][m_sel] = cf_word;
          m_cnt++;
          if (m_cnt == 8) m_ph = 2;
        end else begin
          m_acc = m_acc | (32'(cf_word[7:0]) << (8 * m_cnt));
          m_cnt++;
          if (m_cnt == 4) begin
            if (m_cls == 1) m_round = m_acc;
            else if (m_cls == 2) m_lim[m_sel] = m_acc;
            else m_ctrl = m_acc;
            m_ph = 2;
          end
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk("R4 R5 round", round_q, m_round);
      chk("R5 ctrl", ctrl_q, m_ctrl);
      chk("R10 lim_sel", 32'(lim_sel), 32'(m_ctrl[3:0]));
      chk("R10 lim_upper", 32'(lim_upper), 32'(m_lim[m_ctrl[3:0]][31:16]));
      chk("R10 lim_lower", 32'(lim_lower), 32'(m_lim[m_ctrl[3:0]][15:0]));
      chk("R7 R11 rd_coef", 32'(rd_coef), 32'(m_coef[rd_bank][rd_idx]));
    end
  end

  task automatic send(input logic [11:0] w, input logic p);
    ld_n = 1'b0; pause = p; cf_word = w;
    @(posedge clk); #1;
  endtask

  task automatic idle(input logic [11:0] w);
    ld_n = 1'b1; pause = 1'b0; cf_word = w;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 round", round_q, 32'h0);
    chk("R1 ctrl", ctrl_q, 32'h0);
    chk("R1 coef", 32'(rd_coef), 32'h0);

    // round register, upper CF bits junk (R4), value held until 4th word (R5)
    send(12'h200, 0);
    send(12'hF11, 0); send(12'hA22, 0); send(12'h533, 0);
    chk("R5 round before 4th word", round_q, 32'h0);
    send(12'hC44, 0);
    chk("R4 round assembled", round_q, 32'h44332211);
    idle(12'h000);

    // limit register 5, then control selecting it (R3, R10)
    send(12'h405, 0);
    send(12'h0AA, 0); send(12'h0BB, 0); send(12'h0CC, 0); send(12'h0DD, 0);
    idle(12'h000);
    send(12'h600, 0);
    send(12'h005, 0); send(12'h000, 0); send(12'h000, 0); send(12'h000, 0);
    chk("R10 lim_sel", 32'(lim_sel), 32'd5);
    chk("R10 upper", 32'(lim_upper), 32'hDDCC);
    chk("R10 lower", 32'(lim_lower), 32'hBBAA);
    // R9 extra words after completion ignored
    send(12'h07F, 0); send(12'h0EE, 0);
    chk("R9 ctrl after extra words", ctrl_q, 32'h5);
    idle(12'h000);

    // coefficient set at tap 3 with paused cycles carrying junk (R6, R7)
    send(12'h003, 0);
    for (int b = 0; b < 8; b++) begin
      if (b == 3) begin send(12'hFFF, 1); send(12'hEEE, 1); end
      send(12'h100 + 12'(b), 0);
    end
    idle(12'h000);
    rd_bank = 3'd2; rd_idx = 4'd3; #1;
    chk("R7 bank2 tap3", 32'(rd_coef), 32'h102);
    rd_bank = 3'd3; #1;
    chk("R6 bank3 not paused word", 32'(rd_coef), 32'h103);
    rd_bank = 3'd7; #1;
    chk("R11 bank7 tap3", 32'(rd_coef), 32'h107);

    // aborted round load (R8) then a fresh full one
    send(12'h200, 0);
    send(12'h099, 0); send(12'h099, 0); send(12'h099, 0);
    idle(12'h099);
    chk("R8 round after abort", round_q, 32'h44332211);
    send(12'h200, 0);
    send(12'h001, 0); send(12'h002, 0); send(12'h003, 0); send(12'h004, 0);
    chk("R8 round after restart", round_q, 32'h04030201);
    idle(12'h000);

    // reserved class stores nothing (R3)
    send(12'hE00, 0);
    send(12'h011, 0); send(12'h022, 0); send(12'h033, 0); send(12'h044, 0);
    send(12'h055, 0); send(12'h066, 0); send(12'h077, 0); send(12'h088, 0);
    chk("R3 reserved round", round_q, 32'h04030201);
    chk("R3 reserved ctrl", ctrl_q, 32'h5);
    idle(12'h000);

    // words while ld_n high are not stored (R2)
    for (int i = 0; i < 6; i++) idle(12'h200 + 12'(i));
    chk("R2 round idle", round_q, 32'h04030201);

    // a second coefficient tap with a pause on the address word (R6)
    send(12'hFFF, 1);
    send(12'h00A, 0);
    for (int b = 0; b < 8; b++) send(12'h0A0 + 12'(b), 0);
    idle(12'h000);

    // sweep read port against reference (R11)
    for (int b = 0; b < 8; b++) begin
      for (int t = 0; t < 16; t++) begin
        rd_bank = 3'(b); rd_idx = 4'(t);
        @(posedge clk); #1;
      end
    end
    rd_bank = 3'd0; rd_idx = 4'd10; #1;
    chk("R11 bank0 tap10", 32'(rd_coef), 32'h0A0);
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule